// File: doc/BRIEF.md
# Interrupt Distributor Register File

This block is the memory-mapped state store of a multi-core interrupt controller. For a parameterised number of interrupt lines it holds an enable bit, a pending bit, an active bit, an 8-bit priority, an 8-bit target-CPU mask and two trigger-configuration bits. It also holds a global enable flag and exposes a read-only type word. All of this state is driven continuously onto flat output vectors, so a separate arbitration stage can consume it without going through the bus.

Software reaches the state through a simple register bus. Each access carries a 12-bit byte offset, a read or write strobe, 32-bit write data, a size code and the index of the requesting CPU. Enable, pending and active bits are changed through separate set and clear windows. Priority and target bytes can be reached with narrow accesses. Reads return data one cycle after the strobe. A bad access raises an error flag. A write that changes pending, priority or routing state raises an update strobe, which tells the arbitration stage to re-evaluate.

Top module: `gicd_regfile`

## Requirements
- R1: After reset every enable, pending, active, priority, target, configuration and global-enable bit is 0, and `bus_rvalid`, `bus_err`, `state_upd` and `bus_rdata` are 0.
- R2: Words at 0x100/0x180 (enable), 0x200/0x280 (pending) and 0x300/0x380 (active) are set and clear windows. Word n covers lines 32n..32n+31, and bit k of the word is line 32n+k. Writing 1 to a bit in a set window sets that bit, and writing 1 in a clear window clears it. Zero bits leave the state unchanged. Both windows read back the current state word.
- R3: In word 0 of the pending set and clear windows, bits 15:0 (software-generated interrupts) cannot be changed. Writes to the other bits of that word behave normally.
- R4: Priority byte of line n is at 0x400+n. Byte, halfword and word accesses are legal when naturally aligned. The lowest line sits in bits 7:0 and the higher lines in the higher bytes.
- R5: Target byte of line n (n ≥ 32) is at 0x800+n. It can be read or written as a byte, or as a word. A word access aligns the offset down to a multiple of 4 and packs the four bytes with the lowest line in bits 7:0.
- R6: Any read of a target offset for lines 0–31 returns the one-hot mask of `bus_cpu` (bit `bus_cpu` set) in each of the four bytes. A write there is accepted without error but changes nothing and raises no update strobe.
- R7: Offset 0x004 reads as ((NUM_CPUS−1) << 5) | (NUM_LINES/32 − 1). A write to it is ignored.
- R8: Configuration words at 0xC00 + 4m, for m < 2·NUM_LINES/32, store and read back all 32 bits. Word m holds lines 16m..16m+15 at two bits per line.
- R9: Bit 0 of the control word at 0x000 stores the global enable, reads back, and drives `dist_en`.
- R10: `state_upd` pulses for one cycle after each legal write to a pending window, the priority bytes or a target of line ≥ 32. It stays low for every other write.
- R11: An access is an error if it hits an unmapped offset, uses size code 3, is misaligned, hits a halfword target, uses a non-word size on a word register, or has an index beyond the implemented lines. An erroneous read returns 0, an erroneous write changes nothing, and both pulse `bus_err`.
- R12: Size codes are 0 byte, 1 halfword, 2 word. `bus_rdata`, `bus_rvalid` and `bus_err` become valid in the cycle after the strobe. `bus_rdata` holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_size | input | 2 | Size code: 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Write data, lowest byte in bits 7:0 |
| bus_cpu | input | CPU_W | Index of the requesting CPU |
| bus_rdata | output | 32 | Read data |
| bus_rvalid | output | 1 | Read data valid pulse |
| bus_err | output | 1 | Access error pulse |
| state_upd | output | 1 | Re-evaluation request pulse |
| dist_en | output | 1 | Global enable |
| line_en | output | NUM_LINES | Enable bit per line |
| line_pend | output | NUM_LINES | Pending bit per line |
| line_act | output | NUM_LINES | Active bit per line |
| line_prio | output | 8·NUM_LINES | Priority byte per line |
| line_tgt | output | 8·NUM_LINES | Target mask per line |
| line_cfg | output | 2·NUM_LINES | Configuration bits per line |

## Verification
Some rules are checked on every cycle: the protected low pending bits never move, a set and a clear never hit one bank together, byte banks hold steady without a write enable, erroneous reads return zero, update pulses only follow error-free writes, and a low-target read always returns four equal one-hot bytes. Other behaviour only the bench's scenarios can show. This covers the exact OR and AND-NOT arithmetic of the windows, the packing and down-alignment of narrow priority and target accesses, the type word's value, and writes that must leave the output vectors untouched.

// File: rtl/gicd_pkg.sv
package gicd_pkg;

  localparam int ADDR_W = 12;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  typedef enum logic [3:0] {
    RG_NONE,
    RG_CTRL,
    RG_TYPE,
    RG_EN_SET,
    RG_EN_CLR,
    RG_PD_SET,
    RG_PD_CLR,
    RG_AC_SET,
    RG_AC_CLR,
    RG_PRIO,
    RG_TGT,
    RG_CFG
  } region_e;

  function automatic logic [31:0] lane_mask(input logic [3:0] bm);
    return {{8{bm[3]}}, {8{bm[2]}}, {8{bm[1]}}, {8{bm[0]}}};
  endfunction

endpackage

// File: rtl/gicd_decode.sv
module gicd_decode
  import gicd_pkg::*;
#(
  parameter int NUM_LINES = 64
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output region_e           region,
  output logic              legal,
  output logic [5:0]        word_idx,
  output logic [9:0]        line_base,
  output logic [3:0]        byte_mask
);
  localparam int NW = NUM_LINES / 32;
  localparam logic [10:0] LINES_L = 11'(NUM_LINES);
  localparam logic [5:0]  NW_L    = 6'(NW);
  localparam logic [6:0]  CFG_L   = 7'(2 * NW);

  logic word_ok;

  always_comb begin
    region    = RG_NONE;
    legal     = 1'b0;
    word_idx  = addr[7:2];
    line_base = addr[9:0];
    byte_mask = 4'b0000;
    word_ok   = (size == SZ_WORD) && (addr[1:0] == 2'b00);
    if (addr[11:10] == 2'b01) begin
      region = RG_PRIO;
      case (size)
        SZ_BYTE: begin byte_mask = 4'b0001; legal = 1'b1; end
        SZ_HALF: begin byte_mask = 4'b0011; legal = !addr[0]; end
        SZ_WORD: begin byte_mask = 4'b1111; legal = (addr[1:0] == 2'b00); end
        default: legal = 1'b0;
      endcase
      legal = legal && ({1'b0, addr[9:0]} < LINES_L);
    end else if (addr[11:10] == 2'b10) begin
      region = RG_TGT;
      if (size == SZ_BYTE) begin
        byte_mask = 4'b0001;
        legal     = 1'b1;
      end else if (size == SZ_WORD) begin
        line_base = {addr[9:2], 2'b00};
        byte_mask = 4'b1111;
        legal     = 1'b1;
      end
      legal = legal && ({1'b0, addr[9:0]} < LINES_L);
    end else if (addr[11:8] == 4'hC) begin
      region = RG_CFG;
      legal  = word_ok && ({1'b0, addr[7:2]} < CFG_L);
    end else if ((addr[11:10] == 2'b00) && (addr[9:8] != 2'b00)) begin
      word_idx = {1'b0, addr[6:2]};
      legal    = word_ok && ({1'b0, addr[6:2]} < NW_L);
      case (addr[9:7])
        3'b010:  region = RG_EN_SET;
        3'b011:  region = RG_EN_CLR;
        3'b100:  region = RG_PD_SET;
        3'b101:  region = RG_PD_CLR;
        3'b110:  region = RG_AC_SET;
        3'b111:  region = RG_AC_CLR;
        default: begin region = RG_NONE; legal = 1'b0; end
      endcase
    end else if (addr[11:3] == 9'd0) begin
      region = addr[2] ? RG_TYPE : RG_CTRL;
      legal  = word_ok;
    end
    if (region == RG_NONE) legal = 1'b0;
  end

endmodule

// File: rtl/gicd_bitbank.sv
module gicd_bitbank #(
  parameter int          NW    = 2,
  parameter logic [31:0] PROT0 = 32'hFFFF_FFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic             clr_en,
  input  logic [4:0]       idx,
  input  logic [31:0]      wdata,
  output logic [NW*32-1:0] state
);
  logic [NW*32-1:0] st_q, st_d;
  logic [31:0]      eff;

  always_comb begin
    st_d = st_q;
    eff  = (idx == 5'd0) ? (wdata & PROT0) : wdata;
    for (int w = 0; w < NW; w++) begin
      if (idx == 5'(w)) begin
        if (set_en) st_d[w*32 +: 32] = st_q[w*32 +: 32] | eff;
        if (clr_en) st_d[w*32 +: 32] = st_q[w*32 +: 32] & ~eff;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                st_q <= '0;
    else if (set_en || clr_en) st_q <= st_d;
  end

  assign state = st_q;

  // R2
  setclr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_en && clr_en));

  generate
    if (PROT0 != 32'hFFFF_FFFF) begin : g_prot
      // R3
      prot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(st_q[31:0] & ~PROT0));
    end
  endgenerate

endmodule

// File: rtl/gicd_bytebank.sv
module gicd_bytebank #(
  parameter int NUM_LINES  = 64,
  parameter int LOCK_LINES = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [9:0]             base,
  input  logic [3:0]             bmask,
  input  logic [31:0]            wdata,
  output logic [NUM_LINES*8-1:0] bytes_o
);
  generate
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      if (i < LOCK_LINES) begin : g_fixed
        assign bytes_o[i*8 +: 8] = 8'h00;
      end else begin : g_reg
        logic [10:0] rel;
        logic        hit;
        logic [7:0]  q, d;
        always_comb begin
          rel = 11'(i) - {1'b0, base};
          hit = wr_en && (rel < 11'd4) && bmask[rel[1:0]];
          d   = wdata[rel[1:0]*8 +: 8];
        end
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)   q <= 8'h00;
          else if (hit) q <= d;
        end
        assign bytes_o[i*8 +: 8] = q;
      end
    end
  endgenerate

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(bytes_o));

endmodule

// File: rtl/gicd_regfile.sv
module gicd_regfile
  import gicd_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int NUM_CPUS  = 4,
  localparam int CPU_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic                   bus_rd,
  input  logic                   bus_wr,
  input  logic [1:0]             bus_size,
  input  logic [31:0]            bus_wdata,
  input  logic [CPU_W-1:0]       bus_cpu,
  output logic [31:0]            bus_rdata,
  output logic                   bus_rvalid,
  output logic                   bus_err,
  output logic                   state_upd,
  output logic                   dist_en,
  output logic [NUM_LINES-1:0]   line_en,
  output logic [NUM_LINES-1:0]   line_pend,
  output logic [NUM_LINES-1:0]   line_act,
  output logic [NUM_LINES*8-1:0] line_prio,
  output logic [NUM_LINES*8-1:0] line_tgt,
  output logic [NUM_LINES*2-1:0] line_cfg
);
  localparam int NW        = NUM_LINES / 32;
  localparam int CFG_WORDS = 2 * NW;
  localparam logic [10:0] LINES_L = 11'(NUM_LINES);
  localparam logic [31:0] TYPE_WORD = (32'(NUM_CPUS - 1) << 5) | 32'(NW - 1);
  localparam logic [31:0] SGI_KEEP  = 32'hFFFF_0000;

  region_e     region;
  logic        legal;
  logic [5:0]  word_idx;
  logic [9:0]  line_base;
  logic [3:0]  byte_mask;

  gicd_decode #(.NUM_LINES(NUM_LINES)) u_dec (
    .addr(bus_addr), .size(bus_size), .region(region), .legal(legal),
    .word_idx(word_idx), .line_base(line_base), .byte_mask(byte_mask)
  );

  logic wr_ok, tgt_high;
  assign wr_ok    = bus_wr && legal;
  assign tgt_high = (line_base >= 10'd32);

  gicd_bitbank #(.NW(NW), .PROT0(32'hFFFF_FFFF)) u_en (
    .clk(clk), .rst_n(rst_n),
    .set_en(wr_ok && region == RG_EN_SET), .clr_en(wr_ok && region == RG_EN_CLR),
    .idx(word_idx[4:0]), .wdata(bus_wdata), .state(line_en)
  );
  gicd_bitbank #(.NW(NW), .PROT0(SGI_KEEP)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .set_en(wr_ok && region == RG_PD_SET), .clr_en(wr_ok && region == RG_PD_CLR),
    .idx(word_idx[4:0]), .wdata(bus_wdata), .state(line_pend)
  );
  gicd_bitbank #(.NW(NW), .PROT0(32'hFFFF_FFFF)) u_act (
    .clk(clk), .rst_n(rst_n),
    .set_en(wr_ok && region == RG_AC_SET), .clr_en(wr_ok && region == RG_AC_CLR),
    .idx(word_idx[4:0]), .wdata(bus_wdata), .state(line_act)
  );

  gicd_bytebank #(.NUM_LINES(NUM_LINES), .LOCK_LINES(0)) u_prio (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ok && region == RG_PRIO),
    .base(line_base), .bmask(byte_mask), .wdata(bus_wdata), .bytes_o(line_prio)
  );
  gicd_bytebank #(.NUM_LINES(NUM_LINES), .LOCK_LINES(32)) u_tgt (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ok && region == RG_TGT),
    .base(line_base), .bmask(byte_mask), .wdata(bus_wdata), .bytes_o(line_tgt)
  );

  // configuration words and global enable
  logic [CFG_WORDS*32-1:0] cfg_q, cfg_d;
  logic                    cfg_we;
  logic                    ctrl_q, ctrl_d, ctrl_we;

  always_comb begin
    cfg_we  = wr_ok && (region == RG_CFG);
    ctrl_we = wr_ok && (region == RG_CTRL);
    ctrl_d  = bus_wdata[0];
    cfg_d   = cfg_q;
    for (int w = 0; w < CFG_WORDS; w++)
      if (word_idx == 6'(w)) cfg_d[w*32 +: 32] = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= 1'b0;
    else if (ctrl_we) ctrl_q <= ctrl_d;
  end

  assign dist_en  = ctrl_q;
  assign line_cfg = cfg_q;

  // read path
  logic [3:0][7:0] pb, tb;
  logic [10:0]     lidx;
  logic [7:0]      cpu_oh;
  logic [31:0]     rd_word;

  always_comb begin
    lidx = '0;
    for (int b = 0; b < 4; b++) begin
      lidx = {1'b0, line_base} + 11'(b);
      if (lidx < LINES_L) begin
        pb[b] = line_prio[lidx*8 +: 8];
        tb[b] = line_tgt[lidx*8 +: 8];
      end else begin
        pb[b] = 8'h00;
        tb[b] = 8'h00;
      end
    end
    cpu_oh = 8'(1) << bus_cpu;
    case (region)
      RG_CTRL:              rd_word = {31'd0, ctrl_q};
      RG_TYPE:              rd_word = TYPE_WORD;
      RG_EN_SET, RG_EN_CLR: rd_word = line_en[word_idx[4:0]*32 +: 32];
      RG_PD_SET, RG_PD_CLR: rd_word = line_pend[word_idx[4:0]*32 +: 32];
      RG_AC_SET, RG_AC_CLR: rd_word = line_act[word_idx[4:0]*32 +: 32];
      RG_PRIO:              rd_word = pb & lane_mask(byte_mask);
      RG_TGT:               rd_word = tgt_high ? (tb & lane_mask(byte_mask)) : {4{cpu_oh}};
      RG_CFG:               rd_word = cfg_q[word_idx*32 +: 32];
      default:              rd_word = 32'd0;
    endcase
  end

  // response registers
  logic [31:0] rdata_q, rdata_d;
  logic        rvalid_q, rvalid_d, err_q, err_d, upd_q, upd_d;

  always_comb begin
    rdata_d  = legal ? rd_word : 32'd0;
    rvalid_d = bus_rd;
    err_d    = (bus_rd || bus_wr) && !legal;
    upd_d    = wr_ok && ((region == RG_PD_SET) || (region == RG_PD_CLR) ||
                         (region == RG_PRIO) || ((region == RG_TGT) && tgt_high));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= 32'd0;
    else if (bus_rd) rdata_q <= rdata_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
      upd_q    <= 1'b0;
    end else begin
      rvalid_q <= rvalid_d;
      err_q    <= err_d;
      upd_q    <= upd_d;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
  assign bus_err    = err_q;
  assign state_upd  = upd_q;

  // R11
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && bus_rvalid) |-> (bus_rdata == 32'd0));

  // R10
  upd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_upd |-> ($past(bus_wr) && !bus_err));

  // R12
  rvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_rd));

  // R6
  low_tgt_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && legal && region == RG_TGT && !tgt_high) |=>
      (($countones(bus_rdata[7:0]) == 1) && (bus_rdata[15:8] == bus_rdata[7:0]) &&
       (bus_rdata[31:16] == bus_rdata[15:0])));

endmodule

// File: tb/gicd_regfile_test.sv
module gicd_regfile_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_size = 2'd2;
  logic [31:0] bus_wdata = '0;
  logic [1:0]  bus_cpu = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, bus_err, state_upd, dist_en;
  logic [63:0]  line_en, line_pend, line_act;
  logic [511:0] line_prio, line_tgt;
  logic [127:0] line_cfg;

  gicd_regfile #(.NUM_LINES(64), .NUM_CPUS(4)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_cpu(bus_cpu),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .bus_err(bus_err),
    .state_upd(state_upd), .dist_en(dist_en), .line_en(line_en), .line_pend(line_pend),
    .line_act(line_act), .line_prio(line_prio), .line_tgt(line_tgt), .line_cfg(line_cfg)
  );

  always #(CLK_P/2) clk = ~clk;

  typedef struct {
    logic [31:0] data;
    logic        err;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0, n_err = 0;
  bit   done = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  // driver tasks: called at a falling edge, return at a falling edge
  task automatic do_wr(input logic [11:0] a, input logic [1:0] sz, input logic [31:0] d,
                       input bit exp_err, input bit exp_upd, input string tag);
    bus_addr = a; bus_size = sz; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    check(bus_err == exp_err, {tag, " err"}, 64'(bus_err), 64'(exp_err));
    check(state_upd == exp_upd, {tag, " upd"}, 64'(state_upd), 64'(exp_upd));
  endtask

  task automatic do_rd(input logic [11:0] a, input logic [1:0] sz, input logic [1:0] cpu,
                       input logic [31:0] d, input bit exp_err, input string tag);
    exp_t e;
    e.data = d; e.err = exp_err; e.tag = tag;
    exp_q.push_back(e);
    bus_addr = a; bus_size = sz; bus_cpu = cpu; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // monitor: pops the scoreboard when a response appears
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R12 unexpected response", 64'(bus_rdata), 64'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(bus_rdata == e.data, {e.tag, " data"}, 64'(bus_rdata), 64'(e.data));
        check(bus_err == e.err, {e.tag, " err"}, 64'(bus_err), 64'(e.err));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(line_en == 0 && line_pend == 0 && line_act == 0, "R1 bit vectors", {line_en[31:0], line_pend[31:0]}, 64'd0);
    check(line_prio == 0 && line_tgt == 0 && line_cfg == 0 && !dist_en, "R1 byte vectors", 64'(line_prio[63:0]), 64'd0);
    check(!bus_rvalid && !bus_err && !state_upd && bus_rdata == 0, "R1 outputs", 64'(bus_rdata), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7 type word, write ignored
    do_rd(12'h004, 2'd2, 2'd0, 32'h0000_0061, 1'b0, "R7 type read");
    do_wr(12'h004, 2'd2, 32'hFFFF_FFFF, 1'b0, 1'b0, "R7 type write");
    do_rd(12'h004, 2'd2, 2'd0, 32'h0000_0061, 1'b0, "R7 type unchanged");

    // R9 control
    do_wr(12'h000, 2'd2, 32'h0000_0001, 1'b0, 1'b0, "R9 ctrl write");
    check(dist_en == 1'b1, "R9 dist_en", 64'(dist_en), 64'd1);
    do_rd(12'h000, 2'd2, 2'd0, 32'h0000_0001, 1'b0, "R9 ctrl read");

    // R2 enable windows
    do_wr(12'h100, 2'd2, 32'h0000_00F0, 1'b0, 1'b0, "R2 en set a");
    do_wr(12'h100, 2'd2, 32'h0000_000F, 1'b0, 1'b0, "R2 en set b");
    do_wr(12'h180, 2'd2, 32'h0000_0030, 1'b0, 1'b0, "R2 en clr");
    check(line_en[31:0] == 32'h0000_00CF, "R2 en vec", 64'(line_en[31:0]), 64'hCF);
    do_rd(12'h180, 2'd2, 2'd0, 32'h0000_00CF, 1'b0, "R2 en clr window read");
    do_wr(12'h104, 2'd2, 32'h8000_0001, 1'b0, 1'b0, "R2 en set word1");
    check(line_en[63:32] == 32'h8000_0001, "R2 en word1 vec", 64'(line_en[63:32]), 64'h8000_0001);
    do_rd(12'h104, 2'd2, 2'd0, 32'h8000_0001, 1'b0, "R2 en set window read");

    // R3 pending protection, R10 update strobe
    do_wr(12'h200, 2'd2, 32'h0000_FFFF, 1'b0, 1'b1, "R3 pend protected set");
    check(line_pend == 64'd0, "R3 pend unchanged", line_pend, 64'd0);
    do_wr(12'h200, 2'd2, 32'hFFFF_FFFF, 1'b0, 1'b1, "R3 pend set all");
    check(line_pend[31:0] == 32'hFFFF_0000, "R3 pend word0", 64'(line_pend[31:0]), 64'hFFFF_0000);
    do_wr(12'h280, 2'd2, 32'h0001_0001, 1'b0, 1'b1, "R10 pend clr");
    check(line_pend[31:0] == 32'hFFFE_0000, "R2 pend clr", 64'(line_pend[31:0]), 64'hFFFE_0000);
    do_wr(12'h204, 2'd2, 32'h0000_0005, 1'b0, 1'b1, "R10 pend set word1");
    do_rd(12'h284, 2'd2, 2'd0, 32'h0000_0005, 1'b0, "R2 pend word1 read");

    // R2 active windows
    do_wr(12'h304, 2'd2, 32'h00FF_0000, 1'b0, 1'b0, "R10 act set no upd");
    do_wr(12'h384, 2'd2, 32'h000F_0000, 1'b0, 1'b0, "R2 act clr");
    check(line_act == 64'h00F0_0000_0000_0000, "R2 act vec", line_act, 64'h00F0_0000_0000_0000);

    // R4 priority
    do_wr(12'h408, 2'd2, 32'h4433_2211, 1'b0, 1'b1, "R4 prio word write");
    check(line_prio[64 +: 32] == 32'h4433_2211, "R4 prio lanes", 64'(line_prio[64 +: 32]), 64'h4433_2211);
    do_rd(12'h408, 2'd2, 2'd0, 32'h4433_2211, 1'b0, "R4 prio word read");
    do_rd(12'h40A, 2'd0, 2'd0, 32'h0000_0033, 1'b0, "R4 prio byte read");
    do_wr(12'h40C, 2'd1, 32'h1234_BBAA, 1'b0, 1'b1, "R4 prio half write");
    check(line_prio[96 +: 32] == 32'h0000_BBAA, "R4 prio half lanes", 64'(line_prio[96 +: 32]), 64'hBBAA);
    do_rd(12'h40C, 2'd1, 2'd0, 32'h0000_BBAA, 1'b0, "R4 prio half read");
    do_wr(12'h43F, 2'd0, 32'h0000_007E, 1'b0, 1'b1, "R4 prio last byte");
    do_rd(12'h43F, 2'd0, 2'd0, 32'h0000_007E, 1'b0, "R4 prio last read");

    // R5 targets high
    do_wr(12'h822, 2'd0, 32'h0000_0005, 1'b0, 1'b1, "R5 tgt byte write");
    do_rd(12'h823, 2'd2, 2'd0, 32'h0005_0000, 1'b0, "R5 tgt word read aligned");
    do_wr(12'h825, 2'd2, 32'h0804_0201, 1'b0, 1'b1, "R5 tgt word write aligned");
    check(line_tgt[288 +: 32] == 32'h0804_0201, "R5 tgt lanes", 64'(line_tgt[288 +: 32]), 64'h0804_0201);
    do_rd(12'h826, 2'd0, 2'd0, 32'h0000_0004, 1'b0, "R5 tgt byte read");

    // R6 targets low
    do_rd(12'h804, 2'd2, 2'd2, 32'h0404_0404, 1'b0, "R6 low tgt cpu2");
    do_rd(12'h800, 2'd2, 2'd0, 32'h0101_0101, 1'b0, "R6 low tgt cpu0");
    do_wr(12'h800, 2'd2, 32'hFFFF_FFFF, 1'b0, 1'b0, "R6 low tgt write");
    check(line_tgt[255:0] == '0, "R6 low tgt vec", 64'(line_tgt[63:0]), 64'd0);
    do_rd(12'h81F, 2'd0, 2'd3, 32'h0808_0808, 1'b0, "R6 low tgt cpu3");

    // R8 configuration
    do_wr(12'hC0C, 2'd2, 32'hA5A5_A5A5, 1'b0, 1'b0, "R8 cfg write");
    check(line_cfg[96 +: 32] == 32'hA5A5_A5A5, "R8 cfg vec", 64'(line_cfg[96 +: 32]), 64'hA5A5_A5A5);
    do_rd(12'hC0C, 2'd2, 2'd0, 32'hA5A5_A5A5, 1'b0, "R8 cfg read");

    // R11 errors
    do_wr(12'hC10, 2'd2, 32'hFFFF_FFFF, 1'b1, 1'b0, "R11 cfg out of range");
    do_rd(12'h050, 2'd2, 2'd0, 32'h0, 1'b1, "R11 unmapped read");
    do_wr(12'h100, 2'd0, 32'hFFFF_FFFF, 1'b1, 1'b0, "R11 byte on word reg");
    check(line_en[31:0] == 32'h0000_00CF, "R11 en unchanged", 64'(line_en[31:0]), 64'hCF);
    do_wr(12'h108, 2'd2, 32'hFFFF_FFFF, 1'b1, 1'b0, "R11 en word2");
    do_rd(12'h401, 2'd1, 2'd0, 32'h0, 1'b1, "R11 misaligned half");
    do_wr(12'h420, 2'd3, 32'hFFFF_FFFF, 1'b1, 1'b0, "R11 size code 3");
    check(line_prio[256 +: 32] == 32'd0, "R11 prio unchanged", 64'(line_prio[256 +: 32]), 64'd0);
    do_rd(12'h824, 2'd1, 2'd0, 32'h0, 1'b1, "R11 half target");
    do_rd(12'h440, 2'd0, 2'd0, 32'h0, 1'b1, "R11 prio beyond lines");

    // R12 rdata holds after a read
    repeat (2) @(negedge clk);
    check(bus_rdata == 32'd0 && !bus_rvalid, "R12 hold", 64'(bus_rdata), 64'd0);
    check(exp_q.size() == 0, "R12 all responses", 64'(exp_q.size()), 64'd0);
    summary();
  end

endmodule